// File: doc/BRIEF.md
# Dual Byte FIFO with Threshold and Idle Interrupts

This block holds the two byte queues that sit between a register interface and the shift engine of a serial bus controller. The host side writes bytes into the transmit queue and reads bytes out of the receive queue. The engine side takes bytes from the transmit queue and deposits received bytes into the receive queue. The bus protocol engine itself lives outside this block.

A 32-bit control word enables each queue and sets a threshold for each. Those thresholds raise a "transmit nearly drained" interrupt and a "receive nearly full" interrupt. Pushing into a full queue or popping from an empty one is recorded as an overrun or underrun. A receive queue that holds a partial batch below its threshold, with no new byte arriving for a programmable number of clocks, raises an idle interrupt. Software uses that interrupt to drain the leftover bytes.

All seven causes latch into a sticky status word that is cleared by writing one to a bit. A per-cause enable mask gates them onto a single interrupt line. A 32-bit status word reports the level, full and empty state of both queues.

Top module: `sbuf_dual_fifo`

## Requirements
- R1: After a synchronous reset both levels are 0, both empty flags are 1, both full flags are 0, the interrupt status word is 0 and the interrupt line is low.
- R2: Each queue returns bytes in the order they were accepted. A successful pop loads the head byte into that side's read-data register at the clock edge of the pop, and the register holds it until the next successful pop. Levels change at the edge of a push or pop.
- R3: The queue status word `fifo_stat` has the transmit level at bits 6:0, transmit full at bit 7 and transmit empty at bit 8. It has the receive level at bits 22:16, receive full at bit 23 and receive empty at bit 24. All other bits are 0.
- R4: Control bit 0 enables the receive queue and bit 1 enables the transmit queue. A disabled queue is emptied at the next edge. Its pushes and pops are ignored, and it raises no interrupt cause.
- R5: A push into a full queue is dropped and leaves the level unchanged, even when the other side pops in the same cycle. It sets status bit 3 for the transmit queue (host push) or status bit 5 for the receive queue (engine push).
- R6: A pop from an empty queue returns nothing and leaves the level and read-data register unchanged, even when the other side pushes in the same cycle. It sets status bit 2 for the transmit queue (engine pop) or status bit 4 for the receive queue (host pop).
- R7: Status bit 0 is set at every edge where the transmit queue is enabled and its level before the edge is at or below the transmit threshold, control bits 22:16.
- R8: Status bit 1 is set at every edge where the receive queue is enabled and its level before the edge is at or above the receive threshold, control bits 10:4.
- R9: Status bit 6 is set when the enabled receive queue has held between 1 and threshold-1 bytes, with no engine push, long enough. The bit is set at the (N+1)-th edge after the last engine push, where N is `trail_limit`. Any engine push restarts the count.
- R10: Status bits are sticky. When `stat_clr_we` is high, a bit with 1 in `stat_clr_mask` is cleared at the edge, unless its cause is present at that same edge, in which case the bit stays set.
- R11: `irq` is high exactly when some status bit and its matching `irq_en` bit are both 1, in the same cycle as the status word.

Ports:

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl | input | 32 | Enables (bits 1:0), receive threshold (10:4), transmit threshold (22:16) |
| trail_limit | input | 4 | Idle clocks before the receive idle interrupt |
| irq_en | input | 7 | Per-cause interrupt enables |
| host_tx_push | input | 1 | Host writes a byte into the transmit queue |
| host_tx_data | input | 8 | Byte written by the host |
| host_rx_pop | input | 1 | Host reads a byte from the receive queue |
| host_rx_data | output | 8 | Last byte read from the receive queue |
| eng_tx_pop | input | 1 | Engine takes a byte from the transmit queue |
| eng_tx_data | output | 8 | Last byte taken from the transmit queue |
| eng_rx_push | input | 1 | Engine delivers a received byte |
| eng_rx_data | input | 8 | Byte delivered by the engine |
| stat_clr_we | input | 1 | Write strobe for the write-one-to-clear status |
| stat_clr_mask | input | 7 | Bits to clear when the strobe is high |
| fifo_stat | output | 32 | Queue levels, full and empty flags |
| irq_stat | output | 7 | Sticky interrupt status |
| irq | output | 1 | Enabled interrupt request |

## Verification
Levels, flags and read-data registers change one edge after the push or pop that causes them. Every status cause is evaluated on the levels held before that edge, so its bit appears one edge after its condition. The idle cause appears N+1 edges after the last receive push. The interrupt line follows the status word in the same cycle. The bench drives inputs just after each rising edge and advances a queue-based reference model on the same rising edge. It compares all outputs at the falling edge, so each result is compared in the first cycle it is due. Directed checks pin the idle count at exactly N and N+1 edges, and the set-wins case of the clear.

// File: rtl/sbuf_pkg.sv
package sbuf_pkg;
  localparam int NUM_CAUSE   = 7;
  localparam int LVL_FIELD_W = 7;
  // interrupt cause positions
  localparam int C_TX_LOW  = 0;
  localparam int C_RX_HIGH = 1;
  localparam int C_TX_UDF  = 2;
  localparam int C_TX_OVF  = 3;
  localparam int C_RX_UDF  = 4;
  localparam int C_RX_OVF  = 5;
  localparam int C_RX_IDLE = 6;
  // control word fields
  localparam int CTL_RX_EN   = 0;
  localparam int CTL_TX_EN   = 1;
  localparam int CTL_RX_TRIG = 4;
  localparam int CTL_TX_TRIG = 16;
  // queue status word fields
  localparam int ST_TX_LVL = 0;
  localparam int ST_TX_FUL = 7;
  localparam int ST_TX_EMP = 8;
  localparam int ST_RX_LVL = 16;
  localparam int ST_RX_FUL = 23;
  localparam int ST_RX_EMP = 24;
endpackage

// File: rtl/sbuf_fifo.sv
module sbuf_fifo #(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int AW   = $clog2(DEPTH),
  localparam int LW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty,
  output logic          ovf,
  output logic          udf
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [LW-1:0] lvl_q;
  logic          do_push, do_pop;

  assign full    = (lvl_q == LW'(DEPTH));
  assign empty   = (lvl_q == '0);
  assign do_push = en & push & ~full;
  assign do_pop  = en & pop & ~empty;
  assign ovf     = en & push & full;
  assign udf     = en & pop & empty;
  assign level   = lvl_q;

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst)         pop_data <= '0;
    else if (do_pop) pop_data <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      wp_q  <= '0;
      rp_q  <= '0;
      lvl_q <= '0;
    end else begin
      if (do_push) wp_q <= wp_q + 1'b1;
      if (do_pop)  rp_q <= rp_q + 1'b1;
      case ({do_push, do_pop})
        2'b10:   lvl_q <= lvl_q + 1'b1;
        2'b01:   lvl_q <= lvl_q - 1'b1;
        default: lvl_q <= lvl_q;
      endcase
    end
  end

  AST_LVL_BOUND: assert property (@(posedge clk) disable iff (rst) lvl_q <= LW'(DEPTH)); // R2
  AST_OVF_HOLD:  assert property (@(posedge clk) disable iff (rst) (en && push && full && !pop) |=> lvl_q == LW'(DEPTH)); // R5
  AST_UDF_HOLD:  assert property (@(posedge clk) disable iff (rst) (en && pop && empty && !push) |=> lvl_q == '0); // R6
  AST_OFF_EMPTY: assert property (@(posedge clk) disable iff (rst) !en |=> lvl_q == '0); // R4
endmodule

// File: rtl/sbuf_idle_timer.sv
module sbuf_idle_timer #(
  parameter int LW  = 5,
  parameter int TW  = 7,
  parameter int CW  = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic [LW-1:0] level,
  input  logic [TW-1:0] trig,
  input  logic          push,
  input  logic [CW-1:0] limit,
  output logic          fire
);
  logic [CW-1:0] cnt_q;
  logic          partial;

  assign partial = en && (level != '0) && (TW'(level) < trig);
  assign fire    = partial && !push && (cnt_q >= limit);

  always_ff @(posedge clk) begin
    if (rst || !partial || push) cnt_q <= '0;
    else if (cnt_q < limit)      cnt_q <= cnt_q + 1'b1;
  end

  AST_IDLE_RESTART: assert property (@(posedge clk) disable iff (rst) push |=> cnt_q == '0); // R9
endmodule

// File: rtl/sbuf_irq_ctrl.sv
module sbuf_irq_ctrl #(
  parameter int N = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] cause,
  input  logic         clr_we,
  input  logic [N-1:0] clr_mask,
  input  logic [N-1:0] en,
  output logic [N-1:0] stat,
  output logic         irq
);
  logic [N-1:0] clr_bits;

  assign clr_bits = clr_we ? clr_mask : '0;

  always_ff @(posedge clk) begin
    if (rst) stat <= '0;
    else     stat <= (stat & ~clr_bits) | cause;
  end

  assign irq = |(stat & en);

  for (genvar i = 0; i < N; i++) begin : g_chk
    AST_SET_WINS:  assert property (@(posedge clk) disable iff (rst) cause[i] |=> stat[i]); // R10
    AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (rst) (clr_bits[i] && !cause[i]) |=> !stat[i]); // R10
    AST_STICKY:    assert property (@(posedge clk) disable iff (rst) (stat[i] && !clr_bits[i]) |=> stat[i]); // R10
  end
endmodule

// File: rtl/sbuf_dual_fifo.sv
module sbuf_dual_fifo
  import sbuf_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int DW    = 8,
  localparam int LW   = $clog2(DEPTH) + 1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [31:0]          ctl,
  input  logic [3:0]           trail_limit,
  input  logic [NUM_CAUSE-1:0] irq_en,
  input  logic                 host_tx_push,
  input  logic [DW-1:0]        host_tx_data,
  input  logic                 host_rx_pop,
  output logic [DW-1:0]        host_rx_data,
  input  logic                 eng_tx_pop,
  output logic [DW-1:0]        eng_tx_data,
  input  logic                 eng_rx_push,
  input  logic [DW-1:0]        eng_rx_data,
  input  logic                 stat_clr_we,
  input  logic [NUM_CAUSE-1:0] stat_clr_mask,
  output logic [31:0]          fifo_stat,
  output logic [NUM_CAUSE-1:0] irq_stat,
  output logic                 irq
);
  logic                   rx_en, tx_en;
  logic [LVL_FIELD_W-1:0] rx_trig, tx_trig;
  logic [LW-1:0]          tx_lvl, rx_lvl;
  logic                   tx_full, tx_empty, rx_full, rx_empty;
  logic                   tx_ovf, tx_udf, rx_ovf, rx_udf, idle_fire;
  logic [NUM_CAUSE-1:0]   cause;
  logic                   unused_ctl_bits;

  assign rx_en   = ctl[CTL_RX_EN];
  assign tx_en   = ctl[CTL_TX_EN];
  assign rx_trig = ctl[CTL_RX_TRIG +: LVL_FIELD_W];
  assign tx_trig = ctl[CTL_TX_TRIG +: LVL_FIELD_W];
  assign unused_ctl_bits = ^{ctl[3:2], ctl[15:11], ctl[31:23]};

  sbuf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_tx (
    .clk(clk), .rst(rst), .en(tx_en),
    .push(host_tx_push), .push_data(host_tx_data),
    .pop(eng_tx_pop), .pop_data(eng_tx_data),
    .level(tx_lvl), .full(tx_full), .empty(tx_empty),
    .ovf(tx_ovf), .udf(tx_udf)
  );

  sbuf_fifo #(.DEPTH(DEPTH), .DW(DW)) u_rx (
    .clk(clk), .rst(rst), .en(rx_en),
    .push(eng_rx_push), .push_data(eng_rx_data),
    .pop(host_rx_pop), .pop_data(host_rx_data),
    .level(rx_lvl), .full(rx_full), .empty(rx_empty),
    .ovf(rx_ovf), .udf(rx_udf)
  );

  sbuf_idle_timer #(.LW(LW), .TW(LVL_FIELD_W), .CW(4)) u_idle (
    .clk(clk), .rst(rst), .en(rx_en), .level(rx_lvl), .trig(rx_trig),
    .push(eng_rx_push), .limit(trail_limit), .fire(idle_fire)
  );

  always_comb begin
    cause            = '0;
    cause[C_TX_LOW]  = tx_en && (LVL_FIELD_W'(tx_lvl) <= tx_trig);
    cause[C_RX_HIGH] = rx_en && (LVL_FIELD_W'(rx_lvl) >= rx_trig);
    cause[C_TX_UDF]  = tx_udf;
    cause[C_TX_OVF]  = tx_ovf;
    cause[C_RX_UDF]  = rx_udf;
    cause[C_RX_OVF]  = rx_ovf;
    cause[C_RX_IDLE] = idle_fire;
  end

  sbuf_irq_ctrl #(.N(NUM_CAUSE)) u_irq (
    .clk(clk), .rst(rst), .cause(cause), .clr_we(stat_clr_we),
    .clr_mask(stat_clr_mask), .en(irq_en), .stat(irq_stat), .irq(irq)
  );

  always_comb begin
    fifo_stat = '0;
    fifo_stat[ST_TX_LVL +: LVL_FIELD_W] = LVL_FIELD_W'(tx_lvl);
    fifo_stat[ST_TX_FUL]                = tx_full;
    fifo_stat[ST_TX_EMP]                = tx_empty;
    fifo_stat[ST_RX_LVL +: LVL_FIELD_W] = LVL_FIELD_W'(rx_lvl);
    fifo_stat[ST_RX_FUL]                = rx_full;
    fifo_stat[ST_RX_EMP]                = rx_empty;
  end

  AST_TX_LOW_SETS:   assert property (@(posedge clk) disable iff (rst) (tx_en && LVL_FIELD_W'(tx_lvl) <= tx_trig) |=> irq_stat[C_TX_LOW]); // R7
  AST_RX_HIGH_SETS:  assert property (@(posedge clk) disable iff (rst) (rx_en && LVL_FIELD_W'(rx_lvl) >= rx_trig) |=> irq_stat[C_RX_HIGH]); // R8
  AST_IDLE_HAS_DATA: assert property (@(posedge clk) disable iff (rst) $rose(irq_stat[C_RX_IDLE]) |-> $past(rx_lvl) != '0); // R9
  AST_FLAGS_EXCL:    assert property (@(posedge clk) disable iff (rst) !(tx_full && tx_empty) && !(rx_full && rx_empty)); // R3
endmodule

// File: tb/sbuf_dual_fifo_tb.sv
module sbuf_dual_fifo_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 16;
  localparam int WD_LIMIT   = 100000;

  logic        clk = 0;
  logic        rst = 1;
  logic [31:0] ctl = 0;
  logic [3:0]  trail_limit = 0;
  logic [6:0]  irq_en = 0;
  logic        host_tx_push = 0, host_rx_pop = 0, eng_tx_pop = 0, eng_rx_push = 0;
  logic [7:0]  host_tx_data = 0, eng_rx_data = 0;
  logic        stat_clr_we = 0;
  logic [6:0]  stat_clr_mask = 0;
  logic [7:0]  host_rx_data, eng_tx_data;
  logic [31:0] fifo_stat;
  logic [6:0]  irq_stat;
  logic        irq;

  int n_chk = 0, n_bad = 0, cyc = 0;
  bit started = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbuf_dual_fifo #(.DEPTH(DEPTH), .DW(8)) dut_i (
    .clk(clk), .rst(rst), .ctl(ctl), .trail_limit(trail_limit), .irq_en(irq_en),
    .host_tx_push(host_tx_push), .host_tx_data(host_tx_data),
    .host_rx_pop(host_rx_pop), .host_rx_data(host_rx_data),
    .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
    .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
    .stat_clr_we(stat_clr_we), .stat_clr_mask(stat_clr_mask),
    .fifo_stat(fifo_stat), .irq_stat(irq_stat), .irq(irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] txq[$], rxq[$];
  logic [6:0] m_stat = 0;
  logic [7:0] m_tx_rd = 0, m_rx_rd = 0;
  int         m_idle = 0;

  always @(posedge clk) begin
    started <= 1;
    cyc <= cyc + 1;
    if (rst) begin
      txq.delete(); rxq.delete();
      m_stat = 0; m_tx_rd = 0; m_rx_rd = 0; m_idle = 0;
    end else begin
      logic [6:0] set;
      int tl, rl, ttrig, rtrig;
      bit partial;
      set = 0;
      tl = txq.size(); rl = rxq.size();
      ttrig = int'(ctl[22:16]); rtrig = int'(ctl[10:4]);
      if (!ctl[1]) txq.delete();
      else begin
        if (tl <= ttrig) set[0] = 1;
        if (eng_tx_pop) begin
          if (tl == 0) set[2] = 1; else m_tx_rd = txq.pop_front();
        end
        if (host_tx_push) begin
          if (tl == DEPTH) set[3] = 1; else txq.push_back(host_tx_data);
        end
      end
      partial = ctl[0] && rl != 0 && rl < rtrig;
      if (!ctl[0]) rxq.delete();
      else begin
        if (rl >= rtrig) set[1] = 1;
        if (host_rx_pop) begin
          if (rl == 0) set[4] = 1; else m_rx_rd = rxq.pop_front();
        end
        if (eng_rx_push) begin
          if (rl == DEPTH) set[5] = 1; else rxq.push_back(eng_rx_data);
        end
      end
      if (partial && !eng_rx_push && m_idle >= int'(trail_limit)) set[6] = 1;
      if (!partial || eng_rx_push) m_idle = 0;
      else if (m_idle < int'(trail_limit)) m_idle++;
      m_stat = (m_stat & ~(stat_clr_we ? stat_clr_mask : 7'd0)) | set;
    end
  end

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  function automatic string tag_of(int b);
    case (b)
      0: return "R7 tx low";
      1: return "R8 rx high";
      2: return "R6 tx underrun";
      3: return "R5 tx overrun";
      4: return "R6 rx underrun";
      5: return "R5 rx overrun";
      default: return "R9 rx idle";
    endcase
  endfunction

  always @(negedge clk) begin
    if (started) begin
      logic [31:0] exp_fs;
      exp_fs = 0;
      exp_fs[6:0]   = 7'(txq.size());
      exp_fs[7]     = (txq.size() == DEPTH);
      exp_fs[8]     = (txq.size() == 0);
      exp_fs[22:16] = 7'(rxq.size());
      exp_fs[23]    = (rxq.size() == DEPTH);
      exp_fs[24]    = (rxq.size() == 0);
      check("R2 R3 R4 queue status", fifo_stat, exp_fs);
      for (int b = 0; b < 7; b++) check(tag_of(b), 32'(irq_stat[b]), 32'(m_stat[b]));
      check("R11 irq line", 32'(irq), 32'(|(m_stat & irq_en)));
      check("R2 rx read data", 32'(host_rx_data), 32'(m_rx_rd));
      check("R2 tx read data", 32'(eng_tx_data), 32'(m_tx_rd));
    end
  end

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    if (cyc == WD_LIMIT) begin
      n_chk++; n_bad++;
      $display("FAIL R2 watchdog actual=%0d expected<%0d", cyc, WD_LIMIT);
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic tick();
    @(posedge clk); #1;
    host_tx_push = 0; host_rx_pop = 0; eng_tx_pop = 0; eng_rx_push = 0;
    stat_clr_we = 0; stat_clr_mask = 0;
  endtask

  function automatic logic [31:0] mk_ctl(bit rxe, bit txe, int rtrig, int ttrig);
    logic [31:0] c;
    c = 0; c[0] = rxe; c[1] = txe; c[10:4] = 7'(rtrig); c[22:16] = 7'(ttrig);
    return c;
  endfunction

  initial begin
    repeat (3) tick();
    rst = 0;
    tick();
    check("R1 reset irq_stat", 32'(irq_stat), 0);
    check("R1 reset fifo_stat", fifo_stat, 32'h0100_0100);
    check("R1 reset irq", 32'(irq), 0);

    ctl = mk_ctl(1, 1, 8, 4); trail_limit = 3; irq_en = 7'h7f;
    tick();

    // R9: five receive bytes then idle
    for (int i = 0; i < 5; i++) begin
      eng_rx_push = 1; eng_rx_data = 8'h30 + 8'(i);
      if (i == 4) begin stat_clr_we = 1; stat_clr_mask = 7'h7f; end
      tick();
    end
    repeat (3) tick();
    check("R9 idle not yet at N edges", 32'(irq_stat[6]), 0);
    tick();
    check("R9 idle set at N+1 edges", 32'(irq_stat[6]), 1);

    // drain receive queue plus one underrun (R6)
    for (int i = 0; i < 6; i++) begin host_rx_pop = 1; tick(); end

    // transmit overrun (R5) and underrun (R6)
    for (int i = 0; i < 18; i++) begin host_tx_push = 1; host_tx_data = 8'(8'h80 + i); tick(); end
    for (int i = 0; i < 19; i++) begin eng_tx_pop = 1; tick(); end

    // receive fill past full, with a pop colliding at full
    for (int i = 0; i < 17; i++) begin eng_rx_push = 1; eng_rx_data = 8'(8'hc0 + i); tick(); end
    eng_rx_push = 1; host_rx_pop = 1; eng_rx_data = 8'hee; tick();
    for (int i = 0; i < 17; i++) begin host_rx_pop = 1; tick(); end

    // R4: disabled transmit queue ignores pushes
    ctl = mk_ctl(1, 0, 8, 4);
    for (int i = 0; i < 3; i++) begin host_tx_push = 1; tick(); end
    check("R4 disabled tx level/flags", 32'(fifo_stat[8:0]), 32'h100);

    // R10: clear all; transmit low cause re-asserts (set wins), overrun clears
    ctl = mk_ctl(1, 1, 8, 4);
    tick();
    stat_clr_we = 1; stat_clr_mask = 7'h7f; tick();
    check("R10 cleared overrun bit", 32'(irq_stat[3]), 0);
    check("R10 set wins over clear", 32'(irq_stat[0]), 1);

    // randomized traffic
    for (int i = 0; i < 4000; i++) begin
      host_tx_push = ($urandom_range(0, 99) < 45);
      host_tx_data = 8'($urandom);
      eng_tx_pop   = ($urandom_range(0, 99) < 40);
      eng_rx_push  = ($urandom_range(0, 99) < 35);
      eng_rx_data  = 8'($urandom);
      host_rx_pop  = ($urandom_range(0, 99) < 30);
      if ($urandom_range(0, 9) == 0) begin
        stat_clr_we = 1; stat_clr_mask = 7'($urandom);
      end
      if (i % 97 == 0)
        ctl = mk_ctl($urandom_range(0, 9) != 0, $urandom_range(0, 9) != 0,
                     $urandom_range(0, DEPTH + 1), $urandom_range(0, DEPTH));
      if (i % 61 == 0) irq_en = 7'($urandom);
      if (i % 211 == 0) trail_limit = 4'($urandom);
      tick();
    end
    tick();
    finish_run();
  end
endmodule